// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block caches recent virtual-page-to-physical-frame translations. A requester presents a virtual page number. The block compares it against the tag of every valid entry at once. In the same cycle it reports either a hit, with the frame number, the protection bits and the dirty bit, or a miss. After a miss, the requester gets the translation from the page table by its own means and installs it through the fill port. The block chooses which entry receives each fill.

A flush input drops every translation in one cycle, for use on a context switch. A mode input selects between two ways of keeping the entries. In hardware-maintained mode, a write lookup that hits an entry with write permission marks that entry dirty. In software-loaded mode, lookups never alter the stored entries, so only the fill port changes them.

Top module: `tlb_fa`

## Requirements
- R1: When `lk_valid` is high and a valid entry's tag equals `lk_vpn`, `lk_hit` is 1 and `lk_miss` is 0 in that same cycle. `lk_pfn`, `lk_perm` and `lk_dirty` then carry that entry's fields. `lk_perm` is ordered bit 2 = read, bit 1 = write, bit 0 = execute.
- R2: When `lk_valid` is high and no valid entry matches, `lk_miss` is 1, `lk_hit` is 0, and `lk_pfn`, `lk_perm` and `lk_dirty` are zero. When `lk_valid` is low, all lookup outputs are zero.
- R3: A cycle with `flush` high invalidates every entry, so every lookup from the next cycle on misses until new fills arrive.
- R4: A fill whose page number matches no valid entry goes to the lowest-numbered invalid entry if any entry is invalid. From the next cycle it hits with the filled frame, permissions and dirty value.
- R5: When all entries are valid, a fill with a new page number replaces the entry named by a round-robin pointer. The pointer is 0 after reset and steps by one, wrapping after the last entry, only on fills that use it.
- R6: A fill whose page number matches a valid entry overwrites that entry in place. It evicts no other entry and never leaves two entries with the same tag.
- R7: When `flush` and `fill_en` are both high in one cycle, the flush takes effect and the fill is discarded.
- R8: With `sw_mode` low, a lookup with `lk_write` high that hits an entry whose write bit (bit 1) is set makes that entry's dirty bit 1 from the next cycle. A write hit on an entry without write permission leaves its dirty bit unchanged.
- R9: With `sw_mode` high, lookups of any kind leave every entry unchanged, including its dirty bit.
- R10: After reset all entries are invalid, so every lookup misses. A lookup in the same cycle as a fill sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_mode | input | 1 | 1 = software-loaded mode, lookups never update entries |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Lookup is for a store access |
| lk_vpn | input | VPN_W (22) | Virtual page number to translate |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_miss | output | 1 | Lookup matched no valid entry |
| lk_pfn | output | PFN_W (22) | Frame number of the matching entry |
| lk_perm | output | 3 | Read, write, execute bits of the matching entry |
| lk_dirty | output | 1 | Dirty bit of the matching entry |
| fill_en | input | 1 | Install a translation this cycle |
| fill_vpn | input | VPN_W (22) | Page number to install |
| fill_pfn | input | PFN_W (22) | Frame number to install |
| fill_perm | input | 3 | Permission bits to install |
| fill_dirty | input | 1 | Initial dirty bit to install |
| flush | input | 1 | Invalidate all entries |

## Verification
Flush and fill can land in the same clock edge. The bench drives both high in one cycle in a directed step, and the random phase does so again through independent flush and fill draws. The outcome is judged at the lookup port: on the following cycles, the filled page and the previously cached pages must all miss. A reference model also keeps the round-robin pointer unmoved across that discarded fill, so any later eviction order exposes a fill that slipped through.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PERM_BITS = 3;
  localparam int PERM_R    = 2;
  localparam int PERM_W    = 1;
  localparam int PERM_X    = 0;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N = 16,
  parameter int W = 22
) (
  input  logic [N-1:0]        valid,
  input  logic [N-1:0][W-1:0] tags,
  input  logic [W-1:0]        key,
  output logic [N-1:0]        match
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = valid[i] && (tags[i] == key);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  valid,
  input  logic [N-1:0]  fill_match,
  input  logic          fill_go,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] rr_q;
  logic [IW-1:0] match_idx, free_idx;
  logic          any_match, any_free, use_rr;

  always_comb begin
    match_idx = '0;
    free_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (fill_match[i]) match_idx = IW'(i);
      if (!valid[i])     free_idx  = IW'(i);
    end
  end

  assign any_match = |fill_match;
  assign any_free  = ~&valid;
  assign use_rr    = fill_go && !any_match && !any_free;
  assign idx       = any_match ? match_idx : (any_free ? free_idx : rr_q);

  always_ff @(posedge clk) begin
    if (rst) rr_q <= '0;
    else if (use_rr) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  AST_RR_STEP: assert property (@(posedge clk) disable iff (rst)
    (fill_go && !any_match && &valid) |=> (rr_q == (($past(rr_q) == LAST) ? '0 : $past(rr_q) + 1'b1))); // R5
  AST_RR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fill_go |=> $stable(rr_q)); // R5
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 22,
  parameter int PFN_W   = 22
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sw_mode,
  input  logic                 lk_valid,
  input  logic                 lk_write,
  input  logic [VPN_W-1:0]     lk_vpn,
  output logic                 lk_hit,
  output logic                 lk_miss,
  output logic [PFN_W-1:0]     lk_pfn,
  output logic [PERM_BITS-1:0] lk_perm,
  output logic                 lk_dirty,
  input  logic                 fill_en,
  input  logic [VPN_W-1:0]     fill_vpn,
  input  logic [PFN_W-1:0]     fill_pfn,
  input  logic [PERM_BITS-1:0] fill_perm,
  input  logic                 fill_dirty,
  input  logic                 flush
);
  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0]                valid_q, dirty_q;
  logic [ENTRIES-1:0][VPN_W-1:0]     tag_q;
  logic [ENTRIES-1:0][PFN_W-1:0]     pfn_q;
  logic [ENTRIES-1:0][PERM_BITS-1:0] perm_q;

  logic [ENTRIES-1:0] lk_match, fill_match;
  logic [IW-1:0]      hit_idx, vic_idx;
  logic               any_hit, fill_go, mark_dirty;

  tlb_cam #(.N(ENTRIES), .W(VPN_W)) u_lk_cam (
    .valid(valid_q), .tags(tag_q), .key(lk_vpn), .match(lk_match)
  );

  tlb_cam #(.N(ENTRIES), .W(VPN_W)) u_fill_cam (
    .valid(valid_q), .tags(tag_q), .key(fill_vpn), .match(fill_match)
  );

  assign fill_go = fill_en && !flush;

  tlb_victim #(.N(ENTRIES), .IW(IW)) u_victim (
    .clk(clk), .rst(rst), .valid(valid_q), .fill_match(fill_match),
    .fill_go(fill_go), .idx(vic_idx)
  );

  // Matches are one-hot, so an OR across entries acts as the read mux.
  always_comb begin
    lk_pfn   = '0;
    lk_perm  = '0;
    lk_dirty = 1'b0;
    hit_idx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_valid && lk_match[i]) begin
        lk_pfn   = lk_pfn | pfn_q[i];
        lk_perm  = lk_perm | perm_q[i];
        lk_dirty = lk_dirty | dirty_q[i];
        hit_idx  = hit_idx | IW'(i);
      end
    end
  end

  assign any_hit    = |lk_match;
  assign lk_hit     = lk_valid && any_hit;
  assign lk_miss    = lk_valid && !any_hit;
  assign mark_dirty = !sw_mode && lk_hit && lk_write && lk_perm[PERM_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (flush) begin
      valid_q <= '0;
    end else begin
      if (mark_dirty) dirty_q[hit_idx] <= 1'b1;
      if (fill_en) begin
        valid_q[vic_idx] <= 1'b1;
        dirty_q[vic_idx] <= fill_dirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[vic_idx]  <= fill_vpn;
      pfn_q[vic_idx]  <= fill_pfn;
      perm_q[vic_idx] <= fill_perm;
    end
  end

  AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match)); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0)); // R3
  AST_FLUSH_OVER_FILL: assert property (@(posedge clk) disable iff (rst)
    (flush && fill_en) |=> !lk_hit); // R7
  AST_FILL_INSTALLS: assert property (@(posedge clk) disable iff (rst)
    fill_go |=> ($countones(valid_q) >= 1)); // R4
  AST_SW_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (sw_mode && !fill_en && !flush) |=> ($stable(valid_q) && $stable(dirty_q))); // R9
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(lk_hit && lk_miss)); // R2
endmodule

// File: tb/sim_tlb_fa.sv
module sim_tlb_fa;
  localparam int N  = 16;
  localparam int VW = 22;
  localparam int PW = 22;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst, sw_mode, lk_valid, lk_write, fill_en, fill_dirty, flush;
  logic [VW-1:0] lk_vpn, fill_vpn;
  logic [PW-1:0] fill_pfn;
  logic [2:0]    fill_perm;
  logic          lk_hit, lk_miss, lk_dirty;
  logic [PW-1:0] lk_pfn;
  logic [2:0]    lk_perm;

  tlb_fa u0 (
    .clk(clk), .rst(rst), .sw_mode(sw_mode), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn),
    .lk_perm(lk_perm), .lk_dirty(lk_dirty), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm), .fill_dirty(fill_dirty), .flush(flush)
  );

  logic          m_valid [N];
  logic [VW-1:0] m_tag   [N];
  logic [PW-1:0] m_pfn   [N];
  logic [2:0]    m_perm  [N];
  logic          m_dirty [N];
  int            m_rr;
  int            checks = 0;
  int            fails  = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int m_find(logic [VW-1:0] vpn);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == vpn) return i;
    return -1;
  endfunction

  function automatic int m_victim(logic [VW-1:0] vpn);
    int h;
    h = m_find(vpn);
    if (h >= 0) return h;
    for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
    h = m_rr;
    m_rr = (m_rr + 1) % N;
    return h;
  endfunction

  // Check the combinational lookup outputs, then advance one clock and the model.
  task automatic step(string tag);
    int h;
    string req;
    #2;
    h = lk_valid ? m_find(lk_vpn) : -1;
    req = (tag != "") ? tag : ((h >= 0) ? "R1" : "R2");
    chk(req, "hit",  32'(lk_hit),  32'(h >= 0));
    chk(req, "miss", 32'(lk_miss), 32'(lk_valid && h < 0));
    chk(req, "pfn",  32'(lk_pfn),  (h >= 0) ? 32'(m_pfn[h]) : 32'd0);
    chk(req, "perm", 32'(lk_perm), (h >= 0) ? 32'(m_perm[h]) : 32'd0);
    chk(req, "dirty", 32'(lk_dirty), (h >= 0) ? 32'(m_dirty[h]) : 32'd0);
    @(posedge clk);
    if (flush) begin
      for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
    end else begin
      if (!sw_mode && lk_write && h >= 0 && m_perm[h][1]) m_dirty[h] = 1'b1;
      if (fill_en) begin
        int v;
        v = m_victim(fill_vpn);
        m_valid[v] = 1'b1; m_tag[v] = fill_vpn; m_pfn[v] = fill_pfn;
        m_perm[v] = fill_perm; m_dirty[v] = fill_dirty;
      end
    end
    @(negedge clk);
    fill_en = 1'b0; flush = 1'b0; lk_valid = 1'b0; lk_write = 1'b0;
  endtask

  task automatic look(logic [VW-1:0] vpn, logic wr, string tag);
    lk_valid = 1'b1; lk_vpn = vpn; lk_write = wr;
    step(tag);
  endtask

  task automatic fill(logic [VW-1:0] vpn, logic [PW-1:0] pfn, logic [2:0] perm);
    fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_perm = perm; fill_dirty = 1'b0;
    step("");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 1'b0; m_dirty[i] = 1'b0; m_tag[i] = '0; m_pfn[i] = '0; m_perm[i] = '0;
    end
    m_rr = 0;
    rst = 1'b1; sw_mode = 1'b0; lk_valid = 1'b0; lk_write = 1'b0; lk_vpn = '0;
    fill_en = 1'b0; fill_vpn = '0; fill_pfn = '0; fill_perm = '0; fill_dirty = 1'b0;
    flush = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: empty after reset
    look(22'd0, 1'b0, "R10");
    look(22'd100, 1'b0, "R10");
    // R4: fill into free entries in order
    for (int i = 0; i < N; i++) fill(22'(100 + i), 22'(5000 + i), 3'b110);
    for (int i = 0; i < N; i++) look(22'(100 + i), 1'b0, "R4");
    // R5: full, round-robin from entry 0
    fill(22'd200, 22'd7000, 3'b110);
    look(22'd100, 1'b0, "R5");
    look(22'd200, 1'b0, "R5");
    fill(22'd201, 22'd7001, 3'b110);
    look(22'd101, 1'b0, "R5");
    // R6: refill existing page in place, entry under pointer survives
    fill(22'd110, 22'd9999, 3'b100);
    look(22'd110, 1'b0, "R6");
    look(22'd102, 1'b0, "R6");
    // R10: lookup concurrent with fill of the same page sees old contents
    lk_valid = 1'b1; lk_vpn = 22'd300;
    fill_en = 1'b1; fill_vpn = 22'd300; fill_pfn = 22'd42; fill_perm = 3'b111; fill_dirty = 1'b0;
    step("R10");
    look(22'd300, 1'b0, "R10");
    // R8: write hit sets dirty only with write permission
    look(22'd111, 1'b1, "R8");
    look(22'd111, 1'b0, "R8");
    look(22'd110, 1'b1, "R8");
    look(22'd110, 1'b0, "R8");
    // R9: software-loaded mode leaves dirty alone
    sw_mode = 1'b1;
    look(22'd112, 1'b1, "R9");
    look(22'd112, 1'b0, "R9");
    sw_mode = 1'b0;
    // R7: flush and fill together
    flush = 1'b1; fill_en = 1'b1; fill_vpn = 22'd400; fill_pfn = 22'd1; fill_perm = 3'b111;
    step("R7");
    look(22'd400, 1'b0, "R7");
    look(22'd103, 1'b0, "R3");
    look(22'd300, 1'b0, "R3");

    // Random phase
    for (int c = 0; c < 4000; c++) begin
      if (c % 500 == 0) sw_mode = $urandom_range(0, 1) != 0;
      lk_valid   = $urandom_range(0, 9) < 8;
      lk_write   = $urandom_range(0, 2) == 0;
      lk_vpn     = 22'($urandom_range(0, 23));
      fill_en    = $urandom_range(0, 9) < 3;
      fill_vpn   = 22'($urandom_range(0, 23));
      fill_pfn   = 22'($urandom);
      fill_perm  = 3'($urandom);
      fill_dirty = $urandom_range(0, 3) == 0;
      flush      = $urandom_range(0, 99) < 2;
      step("");
    end
    finish_run();
  end
endmodule